// File: doc/BRIEF.md
# USB High-Speed Chirp Handshake Controller

This block runs the timed negotiation that decides whether a USB link runs at low, full or high speed after attach and bus reset. It sits next to a ULPI-style transceiver wrapper. It computes the transceiver-select, termination-select and operating-mode fields that the wrapper writes into the PHY's function-control register. It raises a one-cycle write strobe whenever those fields change. It also holds a transmit request while a chirp must go out as a no-PID transmit command.

The block watches the two-bit line state and a high-speed squelch indication. All timing is done by counting clock cycles. The defaults assume a 60 MHz ULPI clock, and every interval is a parameter that can be overridden.

One parameter picks the role. As a peripheral, the block waits for a qualified SE0, sends a Chirp K for a fixed time, and then listens for the host's K/J chirp pairs. As a host, it classifies the attached device from the line state, drives reset, detects the device's chirp, and answers with K/J pairs. In both roles the negotiated speed is reported on `speed`.

Top module: `hsc_chirp_ctrl`

## Requirements
- R1: While and after reset, with no bus activity, the outputs are: `xcvr_sel`=01 (full-speed), `term_sel`=1, `op_mode`=00 (normal), `tx_chirp`=0, `fc_wr`=0. `speed` is 2 (full) for a peripheral and 0 (none) for a host. The speed codes are 0 none, 1 low, 2 full, 3 high.
- R2: `line_state` bit 0 is DP and bit 1 is DM, so 00 is SE0, 01 is J and 10 is K. A peripheral starts its chirp only on the T_SE0_CYC-th consecutive SE0 sample. A shorter SE0 has no effect.
- R3: When a peripheral starts its chirp, the fields become `xcvr_sel`=00, `op_mode`=10 and `term_sel`=1 in the same cycle that `tx_chirp` rises. In that cycle `tx_sym`=0, which means K.
- R4: A peripheral holds `tx_chirp` for exactly T_CHIRPK_CYC cycles. Elaboration rejects T_SE0_CYC + T_CHIRPK_CYC > T_KEND_CYC.
- R5: After its chirp, a peripheral switches to high speed (`term_sel`=0, `op_mode`=00, `xcvr_sel`=00, `speed`=3) once it has seen N_PAIRS K-then-J pairs. Samples taken while `hs_squelch`=1 are not counted.
- R6: If a listening peripheral sees too few pairs within T_LISTEN_CYC cycles, it returns to the full-speed fields with `speed`=2. It starts another chirp only after the line has left SE0 and then shows a new qualified SE0.
- R7: A host classifies a device after a stable line state. A stable K (DM high) gives `speed`=1 and `xcvr_sel`=10, and no reset follows. A stable J (DP high) starts reset with `xcvr_sel`=00, `term_sel`=0 and `op_mode`=10.
- R8: During reset, a host accepts a device chirp after T_KDET_CYC consecutive K samples with `hs_squelch`=0. When that K ends, the host sends N_PAIRS_TX K/J pairs, each symbol lasting T_SYM_CYC cycles. It then sets `op_mode`=00 and `speed`=3.
- R9: If no device chirp is accepted within T_RSTTO_CYC cycles of the start of reset, a host falls back to `xcvr_sel`=01, `term_sel`=1, `op_mode`=00 and `speed`=2.
- R10: `fc_wr` is high for exactly one cycle each time the field triple changes, and is low at all other times.
- R11: High speed, once reported, stays reported until reset, whatever the line does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transceiver clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_state | input | 2 | Bus line state: bit 0 DP, bit 1 DM |
| hs_squelch | input | 1 | 1 when the high-speed differential receiver sees no signal |
| xcvr_sel | output | 2 | Transceiver select field: 00 HS, 01 FS, 10 LS |
| term_sel | output | 1 | Termination select field |
| op_mode | output | 2 | Operating mode field: 00 normal, 10 chirp |
| fc_wr | output | 1 | One-cycle request to write the function-control fields |
| tx_chirp | output | 1 | Request to hold a no-PID chirp transmit |
| tx_sym | output | 1 | Chirp symbol being sent: 0 K, 1 J |
| speed | output | 2 | Negotiated speed: 0 none, 1 low, 2 full, 3 high |

## Verification
The checker evaluates the following on every cycle:
- whenever a chirp is requested, the fields are set for chirping;
- the high-speed, full-speed and low-speed field combinations agree with the reported speed;
- high speed is sticky;
- the write strobe never lasts two cycles;
- a chirp never runs past its length and ends at exactly that length;
- a peripheral's chirp is always preceded by a sampled SE0.

Only the directed scenarios can show the following:
- the exact qualification cycle counts;
- that short SE0 and squelched pairs are ignored;
- the listen and reset timeouts;
- the host's classification;
- the re-arming after fallback.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
   typedef enum logic [1:0] {
      SPD_NONE = 2'd0,
      SPD_LOW  = 2'd1,
      SPD_FULL = 2'd2,
      SPD_HIGH = 2'd3
   } speed_e;

   localparam logic [1:0] LS_SE0 = 2'b00;
   localparam logic [1:0] LS_J   = 2'b01;
   localparam logic [1:0] LS_K   = 2'b10;

   localparam logic [1:0] XS_HS = 2'b00;
   localparam logic [1:0] XS_FS = 2'b01;
   localparam logic [1:0] XS_LS = 2'b10;

   localparam logic [1:0] OM_NORMAL = 2'b00;
   localparam logic [1:0] OM_CHIRP  = 2'b10;

   typedef struct packed {
      logic [1:0] xcvr;
      logic       term;
      logic [1:0] opm;
   } fctl_t;

   localparam fctl_t FC_FS      = '{xcvr: XS_FS, term: 1'b1, opm: OM_NORMAL};
   localparam fctl_t FC_LS      = '{xcvr: XS_LS, term: 1'b1, opm: OM_NORMAL};
   localparam fctl_t FC_PCHIRP  = '{xcvr: XS_HS, term: 1'b1, opm: OM_CHIRP};
   localparam fctl_t FC_HRESET  = '{xcvr: XS_HS, term: 1'b0, opm: OM_CHIRP};
   localparam fctl_t FC_HS      = '{xcvr: XS_HS, term: 1'b0, opm: OM_NORMAL};
endpackage

// File: rtl/hsc_kj_counter.sv
module hsc_kj_counter
   import hsc_pkg::*;
#(
   parameter int N_PAIRS = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic [1:0] line_state,
   input  logic       hs_squelch,
   output logic       pairs_met
);
   localparam int PW = $clog2(N_PAIRS + 1);

   logic [PW-1:0] cnt;
   logic          seen_k;

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         cnt    <= '0;
         seen_k <= 1'b0;
      end else if (!hs_squelch) begin
         if (line_state == LS_K) begin
            seen_k <= 1'b1;
         end else if (line_state == LS_J && seen_k) begin
            seen_k <= 1'b0;
            if (cnt != PW'(N_PAIRS)) cnt <= cnt + 1'b1;
         end
      end
   end

   assign pairs_met = (cnt == PW'(N_PAIRS));
endmodule

// File: rtl/hsc_periph_fsm.sv
module hsc_periph_fsm
   import hsc_pkg::*;
#(
   parameter int CW           = 20,
   parameter int T_SE0_CYC    = 150,
   parameter int T_CHIRPK_CYC = 60000,
   parameter int T_LISTEN_CYC = 60000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line_state,
   input  logic       pairs_met,
   output logic       listening,
   output fctl_t      fc,
   output logic       tx_chirp,
   output speed_e     speed
);
   typedef enum logic [2:0] {P_ARM, P_IDLE, P_CHIRPK, P_LISTEN, P_HS} pst_e;

   pst_e          st;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= P_ARM;
         cnt      <= '0;
         fc       <= FC_FS;
         tx_chirp <= 1'b0;
         speed    <= SPD_FULL;
      end else begin
         case (st)
            P_ARM: begin
               cnt <= '0;
               if (line_state != LS_SE0) st <= P_IDLE;
            end
            P_IDLE: begin
               if (line_state == LS_SE0) begin
                  if (cnt == CW'(T_SE0_CYC - 1)) begin
                     st       <= P_CHIRPK;
                     cnt      <= '0;
                     fc       <= FC_PCHIRP;
                     tx_chirp <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end else begin
                  cnt <= '0;
               end
            end
            P_CHIRPK: begin
               if (cnt == CW'(T_CHIRPK_CYC - 1)) begin
                  st       <= P_LISTEN;
                  cnt      <= '0;
                  tx_chirp <= 1'b0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            P_LISTEN: begin
               if (pairs_met) begin
                  st    <= P_HS;
                  fc    <= FC_HS;
                  speed <= SPD_HIGH;
               end else if (cnt == CW'(T_LISTEN_CYC - 1)) begin
                  st    <= P_ARM;
                  cnt   <= '0;
                  fc    <= FC_FS;
                  speed <= SPD_FULL;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            P_HS:    st <= P_HS;
            default: st <= P_ARM;
         endcase
      end
   end

   assign listening = (st == P_LISTEN);
endmodule

// File: rtl/hsc_host_fsm.sv
module hsc_host_fsm
   import hsc_pkg::*;
#(
   parameter int CW           = 20,
   parameter int T_ATTACH_CYC = 6000,
   parameter int T_KDET_CYC   = 150,
   parameter int T_RSTTO_CYC  = 420000,
   parameter int T_SYM_CYC    = 3000,
   parameter int N_PAIRS_TX   = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line_state,
   input  logic       hs_squelch,
   output fctl_t      fc,
   output logic       tx_chirp,
   output logic       tx_sym,
   output speed_e     speed
);
   localparam int SW = $clog2(N_PAIRS_TX + 1);

   typedef enum logic [2:0] {H_IDLE, H_LS, H_RESET, H_KWAIT, H_CHIRP, H_FS, H_HS} hst_e;

   hst_e          st;
   logic [CW-1:0] cnt;
   logic [CW-1:0] kcnt;
   logic [1:0]    last_line;
   logic [SW-1:0] sent;
   logic          dev_k;
   logic          stable;

   assign dev_k  = (line_state == LS_K) && !hs_squelch;
   assign stable = (line_state == LS_J || line_state == LS_K) && (line_state == last_line);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= H_IDLE;
         cnt       <= '0;
         kcnt      <= '0;
         last_line <= LS_SE0;
         sent      <= '0;
         fc        <= FC_FS;
         tx_chirp  <= 1'b0;
         tx_sym    <= 1'b0;
         speed     <= SPD_NONE;
      end else begin
         case (st)
            H_IDLE: begin
               last_line <= line_state;
               if (stable) begin
                  if (cnt == CW'(T_ATTACH_CYC - 1)) begin
                     cnt <= '0;
                     if (line_state == LS_K) begin
                        st    <= H_LS;
                        fc    <= FC_LS;
                        speed <= SPD_LOW;
                     end else begin
                        st   <= H_RESET;
                        fc   <= FC_HRESET;
                        kcnt <= '0;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end else begin
                  cnt <= '0;
               end
            end
            H_RESET: begin
               cnt <= cnt + 1'b1;
               if (dev_k) begin
                  if (kcnt == CW'(T_KDET_CYC - 1)) st <= H_KWAIT;
                  else kcnt <= kcnt + 1'b1;
               end else begin
                  kcnt <= '0;
               end
               if (cnt == CW'(T_RSTTO_CYC - 1)) begin
                  st    <= H_FS;
                  fc    <= FC_FS;
                  speed <= SPD_FULL;
               end
            end
            H_KWAIT: begin
               cnt <= cnt + 1'b1;
               if (!dev_k) begin
                  st       <= H_CHIRP;
                  cnt      <= '0;
                  tx_chirp <= 1'b1;
                  tx_sym   <= 1'b0;
                  sent     <= '0;
               end else if (cnt == CW'(T_RSTTO_CYC - 1)) begin
                  st    <= H_FS;
                  fc    <= FC_FS;
                  speed <= SPD_FULL;
               end
            end
            H_CHIRP: begin
               if (cnt == CW'(T_SYM_CYC - 1)) begin
                  cnt <= '0;
                  if (tx_sym) begin
                     tx_sym <= 1'b0;
                     if (sent == SW'(N_PAIRS_TX - 1)) begin
                        st       <= H_HS;
                        tx_chirp <= 1'b0;
                        fc       <= FC_HS;
                        speed    <= SPD_HIGH;
                     end else begin
                        sent <= sent + 1'b1;
                     end
                  end else begin
                     tx_sym <= 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            H_LS, H_FS, H_HS: st <= st;
            default:          st <= H_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hsc_chirp_ctrl.sv
module hsc_chirp_ctrl
   import hsc_pkg::*;
#(
   parameter bit IS_HOST      = 1'b0,
   parameter int CLK_MHZ      = 60,
   parameter int T_SE0_CYC    = CLK_MHZ * 5 / 2,
   parameter int T_CHIRPK_CYC = CLK_MHZ * 1000,
   parameter int T_KEND_CYC   = CLK_MHZ * 7000,
   parameter int T_LISTEN_CYC = CLK_MHZ * 1000,
   parameter int N_PAIRS      = 3,
   parameter int T_ATTACH_CYC = CLK_MHZ * 100,
   parameter int T_KDET_CYC   = CLK_MHZ * 5 / 2,
   parameter int T_RSTTO_CYC  = CLK_MHZ * 7000,
   parameter int T_SYM_CYC    = CLK_MHZ * 50,
   parameter int N_PAIRS_TX   = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line_state,
   input  logic       hs_squelch,
   output logic [1:0] xcvr_sel,
   output logic       term_sel,
   output logic [1:0] op_mode,
   output logic       fc_wr,
   output logic       tx_chirp,
   output logic       tx_sym,
   output logic [1:0] speed
);
   localparam int CW = $clog2(T_KEND_CYC + T_CHIRPK_CYC + T_LISTEN_CYC + T_ATTACH_CYC
                              + T_RSTTO_CYC + 2 * N_PAIRS_TX * T_SYM_CYC + 2);

   if (T_SE0_CYC < 1 || T_CHIRPK_CYC < 1 || T_LISTEN_CYC < 1 || T_ATTACH_CYC < 1
       || T_KDET_CYC < 1 || T_RSTTO_CYC < 1 || T_SYM_CYC < 1) begin : g_bad_time
      $error("hsc_chirp_ctrl: every interval must be at least one cycle");
   end
   if (N_PAIRS < 1 || N_PAIRS_TX < 1) begin : g_bad_pairs
      $error("hsc_chirp_ctrl: pair counts must be at least one");
   end
   if (T_SE0_CYC + T_CHIRPK_CYC > T_KEND_CYC) begin : g_bad_kend
      $error("hsc_chirp_ctrl: chirp K would end after the allowed deadline");
   end

   fctl_t  fc;
   fctl_t  fc_q;
   speed_e speed_i;

   if (IS_HOST) begin : g_host
      hsc_host_fsm #(
         .CW(CW), .T_ATTACH_CYC(T_ATTACH_CYC), .T_KDET_CYC(T_KDET_CYC),
         .T_RSTTO_CYC(T_RSTTO_CYC), .T_SYM_CYC(T_SYM_CYC), .N_PAIRS_TX(N_PAIRS_TX)
      ) u_host (
         .clk(clk), .rst_n(rst_n), .line_state(line_state), .hs_squelch(hs_squelch),
         .fc(fc), .tx_chirp(tx_chirp), .tx_sym(tx_sym), .speed(speed_i)
      );
   end else begin : g_periph
      logic listening;
      logic pairs_met;

      hsc_kj_counter #(.N_PAIRS(N_PAIRS)) u_kj (
         .clk(clk), .rst_n(rst_n), .enable(listening), .line_state(line_state),
         .hs_squelch(hs_squelch), .pairs_met(pairs_met)
      );

      hsc_periph_fsm #(
         .CW(CW), .T_SE0_CYC(T_SE0_CYC), .T_CHIRPK_CYC(T_CHIRPK_CYC),
         .T_LISTEN_CYC(T_LISTEN_CYC)
      ) u_periph (
         .clk(clk), .rst_n(rst_n), .line_state(line_state), .pairs_met(pairs_met),
         .listening(listening), .fc(fc), .tx_chirp(tx_chirp), .speed(speed_i)
      );

      assign tx_sym = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) fc_q <= FC_FS;
      else        fc_q <= fc;
   end

   assign fc_wr    = (fc != fc_q);
   assign xcvr_sel = fc.xcvr;
   assign term_sel = fc.term;
   assign op_mode  = fc.opm;
   assign speed    = speed_i;
endmodule

// File: rtl/hsc_chk.sv
module hsc_chk #(
   parameter bit IS_HOST      = 1'b0,
   parameter int T_CHIRPK_CYC = 60000,
   parameter int T_SYM_CYC    = 3000,
   parameter int N_PAIRS_TX   = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] line_state,
   input logic [1:0] xcvr_sel,
   input logic       term_sel,
   input logic [1:0] op_mode,
   input logic       fc_wr,
   input logic       tx_chirp,
   input logic       tx_sym,
   input logic [1:0] speed
);
   localparam int MAXRUN = IS_HOST ? 2 * N_PAIRS_TX * T_SYM_CYC : T_CHIRPK_CYC;
   localparam int RW     = $clog2(MAXRUN + 2);

   logic [RW-1:0] run;

   always_ff @(posedge clk) begin
      if (!rst_n)        run <= '0;
      else if (tx_chirp) run <= run + 1'b1;
      else               run <= '0;
   end

   assert_chirp_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_chirp |-> (op_mode == 2'b10 && xcvr_sel == 2'b00));

   assert_periph_k_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!IS_HOST && tx_chirp) |-> !tx_sym);

   assert_se0_before_chirp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!IS_HOST && $rose(tx_chirp)) |-> $past(line_state) == 2'b00);

   assert_chirp_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_chirp |-> run < RW'(MAXRUN));

   assert_chirp_exact_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_chirp) |-> run == RW'(MAXRUN));

   assert_hs_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (speed == 2'd3) |-> (term_sel == 1'b0 && op_mode == 2'b00 && xcvr_sel == 2'b00));

   assert_fs_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (speed == 2'd2 && op_mode == 2'b00) |-> (xcvr_sel == 2'b01 && term_sel));

   assert_ls_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (speed == 2'd1) |-> (xcvr_sel == 2'b10 && op_mode == 2'b00));

   assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fc_wr |=> !fc_wr);

   assert_hs_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (speed == 2'd3) |=> (speed == 2'd3));
endmodule

bind hsc_chirp_ctrl hsc_chk #(
   .IS_HOST(IS_HOST), .T_CHIRPK_CYC(T_CHIRPK_CYC), .T_SYM_CYC(T_SYM_CYC),
   .N_PAIRS_TX(N_PAIRS_TX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .line_state(line_state), .xcvr_sel(xcvr_sel),
   .term_sel(term_sel), .op_mode(op_mode), .fc_wr(fc_wr), .tx_chirp(tx_chirp),
   .tx_sym(tx_sym), .speed(speed)
);

// File: tb/hsc_chirp_ctrl_test.sv
`timescale 1ns/1ps
module hsc_chirp_ctrl_test;
   localparam int TSE0 = 10;
   localparam int TCK  = 50;
   localparam int TKE  = 200;
   localparam int TLIS = 100;
   localparam int NPR  = 3;
   localparam int TATT = 8;
   localparam int TKD  = 6;
   localparam int TRTO = 120;
   localparam int TSYM = 4;
   localparam int NPTX = 3;

   localparam logic [1:0] SE0 = 2'b00;
   localparam logic [1:0] J   = 2'b01;
   localparam logic [1:0] K   = 2'b10;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       p_rst_n = 1'b0, h_rst_n = 1'b0;
   logic [1:0] p_line = J, h_line = J;
   logic       p_sq = 1'b1, h_sq = 1'b1;

   logic [1:0] p_xcvr, p_op, p_spd, h_xcvr, h_op, h_spd;
   logic       p_term, p_wr, p_tx, p_sym, h_term, h_wr, h_tx, h_sym;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   hsc_chirp_ctrl #(
      .IS_HOST(1'b0), .T_SE0_CYC(TSE0), .T_CHIRPK_CYC(TCK), .T_KEND_CYC(TKE),
      .T_LISTEN_CYC(TLIS), .N_PAIRS(NPR), .T_ATTACH_CYC(TATT), .T_KDET_CYC(TKD),
      .T_RSTTO_CYC(TRTO), .T_SYM_CYC(TSYM), .N_PAIRS_TX(NPTX)
   ) uut (
      .clk(clk), .rst_n(p_rst_n), .line_state(p_line), .hs_squelch(p_sq),
      .xcvr_sel(p_xcvr), .term_sel(p_term), .op_mode(p_op), .fc_wr(p_wr),
      .tx_chirp(p_tx), .tx_sym(p_sym), .speed(p_spd)
   );

   hsc_chirp_ctrl #(
      .IS_HOST(1'b1), .T_SE0_CYC(TSE0), .T_CHIRPK_CYC(TCK), .T_KEND_CYC(TKE),
      .T_LISTEN_CYC(TLIS), .N_PAIRS(NPR), .T_ATTACH_CYC(TATT), .T_KDET_CYC(TKD),
      .T_RSTTO_CYC(TRTO), .T_SYM_CYC(TSYM), .N_PAIRS_TX(NPTX)
   ) uut_host (
      .clk(clk), .rst_n(h_rst_n), .line_state(h_line), .hs_squelch(h_sq),
      .xcvr_sel(h_xcvr), .term_sel(h_term), .op_mode(h_op), .fc_wr(h_wr),
      .tx_chirp(h_tx), .tx_sym(h_sym), .speed(h_spd)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic reset_p();
      p_rst_n = 1'b0; p_line = J; p_sq = 1'b1;
      step(3);
      p_rst_n = 1'b1;
      step(2);
   endtask

   task automatic reset_h(input logic [1:0] ln);
      h_rst_n = 1'b0; h_line = ln; h_sq = 1'b1;
      step(3);
      h_rst_n = 1'b1;
   endtask

   task automatic kj_pair(input logic sq);
      p_sq = sq; p_line = K; step(3);
      p_line = J; step(3);
   endtask

   // R1: reset values on both roles
   task automatic t_reset_state();
      p_rst_n = 1'b0; h_rst_n = 1'b0;
      step(3);
      chk("R1", "periph xcvr", p_xcvr, 1);
      chk("R1", "periph term", p_term, 1);
      chk("R1", "periph op", p_op, 0);
      chk("R1", "periph speed", p_spd, 2);
      chk("R1", "periph tx", p_tx, 0);
      chk("R1", "periph wr", p_wr, 0);
      chk("R1", "host speed", h_spd, 0);
      chk("R1", "host xcvr", h_xcvr, 1);
      reset_p();
      chk("R1", "periph wr after release", p_wr, 0);
      chk("R1", "periph tx after release", p_tx, 0);
   endtask

   // R2: SE0 one sample short is ignored
   task automatic t_short_se0();
      p_line = SE0; step(TSE0 - 1);
      chk("R2", "tx after short SE0", p_tx, 0);
      p_line = J; step(3);
      chk("R2", "tx after return to J", p_tx, 0);
      chk("R2", "op after short SE0", p_op, 0);
   endtask

   // R2 R3 R4 R5 R10 R11: full peripheral negotiation to high speed
   task automatic t_periph_hs();
      p_line = SE0; step(TSE0 - 1);
      chk("R2", "tx before qualify", p_tx, 0);
      step(1);
      chk("R3", "tx at qualify", p_tx, 1);
      chk("R3", "xcvr chirp", p_xcvr, 0);
      chk("R3", "op chirp", p_op, 2);
      chk("R3", "term chirp", p_term, 1);
      chk("R3", "sym K", p_sym, 0);
      chk("R10", "wr pulse", p_wr, 1);
      p_line = K; p_sq = 1'b0;
      step(1);
      chk("R10", "wr single", p_wr, 0);
      step(TCK - 2);
      chk("R4", "tx last cycle", p_tx, 1);
      step(1);
      chk("R4", "tx ended", p_tx, 0);
      chk("R4", "op listening", p_op, 2);
      kj_pair(1'b1);
      kj_pair(1'b1);
      kj_pair(1'b0);
      kj_pair(1'b0);
      chk("R5", "speed before enough pairs", p_spd, 2);
      chk("R5", "op before enough pairs", p_op, 2);
      kj_pair(1'b0);
      chk("R5", "speed high", p_spd, 3);
      chk("R5", "term high", p_term, 0);
      chk("R5", "op high", p_op, 0);
      chk("R5", "xcvr high", p_xcvr, 0);
      p_line = SE0; p_sq = 1'b1; step(40);
      chk("R11", "speed sticky", p_spd, 3);
      chk("R11", "no new chirp", p_tx, 0);
   endtask

   // R6: listen timeout and rearm
   task automatic t_periph_timeout();
      reset_p();
      p_line = SE0; p_sq = 1'b1;
      step(TSE0 + TCK + TLIS - 1);
      chk("R6", "op still listening", p_op, 2);
      step(1);
      chk("R6", "speed fallback", p_spd, 2);
      chk("R6", "op fallback", p_op, 0);
      chk("R6", "xcvr fallback", p_xcvr, 1);
      chk("R6", "term fallback", p_term, 1);
      chk("R10", "wr at fallback", p_wr, 1);
      step(30);
      chk("R6", "no rechirp while SE0 persists", p_tx, 0);
      chk("R6", "op stays normal", p_op, 0);
      p_line = J; step(2);
      p_line = SE0; step(TSE0);
      chk("R6", "rechirp after rearm", p_tx, 1);
   endtask

   // R7: low-speed device
   task automatic t_host_ls();
      reset_h(K);
      chk("R1", "host speed after release", h_spd, 0);
      step(5);
      chk("R7", "not yet classified", h_spd, 0);
      step(10);
      chk("R7", "speed low", h_spd, 1);
      chk("R7", "xcvr low", h_xcvr, 2);
      chk("R7", "op low", h_op, 0);
      step(30);
      chk("R7", "no reset for LS", h_op, 0);
      chk("R7", "no chirp for LS", h_tx, 0);
   endtask

   // R7 R8: full-speed device that chirps
   task automatic t_host_hs();
      reset_h(J);
      step(12);
      chk("R7", "reset xcvr", h_xcvr, 0);
      chk("R7", "reset term", h_term, 0);
      chk("R7", "reset op", h_op, 2);
      chk("R7", "speed during reset", h_spd, 0);
      h_line = SE0; h_sq = 1'b1; step(5);
      h_line = K; h_sq = 1'b1; step(10);
      h_line = SE0; step(2);
      chk("R8", "squelched K ignored", h_tx, 0);
      h_line = K; h_sq = 1'b0; step(8);
      chk("R8", "no host chirp during device K", h_tx, 0);
      h_line = SE0; h_sq = 1'b1; step(1);
      chk("R8", "host chirp starts", h_tx, 1);
      chk("R8", "first symbol K", h_sym, 0);
      step(TSYM - 1);
      chk("R8", "K held", h_sym, 0);
      step(1);
      chk("R8", "then J", h_sym, 1);
      step(2 * NPTX * TSYM - TSYM - 1);
      chk("R8", "chirp last cycle", h_tx, 1);
      chk("R8", "op during chirp", h_op, 2);
      step(1);
      chk("R8", "chirp done", h_tx, 0);
      chk("R8", "speed high", h_spd, 3);
      chk("R8", "op normal", h_op, 0);
      chk("R8", "term hs", h_term, 0);
   endtask

   // R9: no device chirp
   task automatic t_host_timeout();
      reset_h(J);
      step(12);
      h_line = SE0; h_sq = 1'b1; step(100);
      chk("R9", "still resetting", h_op, 2);
      chk("R9", "speed during reset", h_spd, 0);
      step(20);
      chk("R9", "speed full", h_spd, 2);
      chk("R9", "xcvr full", h_xcvr, 1);
      chk("R9", "term full", h_term, 1);
      chk("R9", "op normal", h_op, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_short_se0();
      t_periph_hs();
      t_periph_timeout();
      t_host_ls();
      t_host_hs();
      t_host_timeout();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule